// File: doc/BRIEF.md
# Double-Buffered DMA Channel

This block is one DMA channel. It moves words between a fixed peripheral FIFO address and memory, and it works from two ping-pong buffer descriptors. Each descriptor holds a start address, a count of transfer units and a few high address bits. Software sets a descriptor up, enables it and sets GO. The channel then drains the active buffer one unit per peripheral request. When a buffer runs out, the channel flags it as done, disables it and switches to the other buffer. If that buffer is enabled it carries on with it; otherwise it waits.

Software reaches the channel through a small register window. The control/status word has two write ports: one sets every bit written as 1, and the other clears every bit written as 1. To stop the channel cleanly, software clears GO and then waits for the HALT status bit. The memory side is a request/acknowledge word port. The peripheral side is a request strobe in and an acknowledge pulse out.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset the control word (read at offset 0x00) is 0x00040, meaning only HALT (bit 6) is set. A write to 0x00 sets each writable bit written as 1. A write to 0x04 clears each writable bit written as 1. Bit map: BE0=0, D0=1, BE1=2, D1=3, AB=4, GO=5, HALT=6, IE=7, NC=8, width=10:9, TS8=11, DR=12, byte-order=13, DS=15, device id=19:16.
- R2: The set port cannot raise D0, D1, AB or HALT. AB and HALT are not changed by either port. D0 and D1 drop only through the clear port.
- R3: A transfer starts when GO is 1, the active buffer's enable is 1, its count is nonzero and per_req is 1. It makes one memory access at {high bits, start}, with mem_size equal to the width field. With DR=0 the access writes per_rdata (mem_we=1). With DR=1 it reads memory (mem_we=0) and drives the returned word on per_wdata. per_ack pulses for one cycle, one cycle after mem_ack.
- R4: Each finished transfer lowers the active count by 1. It also advances the active start address by 1, 2 or 4 for width codes 0, 1 and 2 (8, 16 and 32 bits). Both registers read back their live values.
- R5: When a buffer's count reaches zero, or an enabled buffer with a zero count is active under GO, hardware does three things: it clears that buffer's enable, sets its done flag and toggles AB. No memory access is made for a zero count.
- R6: AB reads 1 while buffer 1 is active, and transfers then use buffer 1's address and count (start 0x14, count 0x18; buffer 0 uses 0x0C and 0x10). Count registers hold the count in bits 15:0 and the high address bits in 19:16.
- R7: If the active buffer is not enabled, no memory access happens, even when per_req is high and the other buffer is enabled.
- R8: After GO is cleared, any transfer in progress completes. HALT then reads 1 and no new access starts. HALT reads 0 again once GO is set.
- R9: irq is high exactly when IE is 1 and at least one of D0, D1 is 1.
- R10: The peripheral address register (0x08) reads back what was written and drives per_addr. The other mode fields, including the device id, are stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | HW+AW | Memory byte address |
| mem_size | output | 2 | Transfer width code |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access completion |
| per_req | input | 1 | Peripheral ready for one transfer |
| per_ack | output | 1 | One-cycle pulse per completed transfer |
| per_addr | output | 32 | Peripheral FIFO address |
| per_rdata | input | DW | Data from the peripheral FIFO |
| per_wdata | output | DW | Data toward the peripheral FIFO |
| irq | output | 1 | Done interrupt |

## Verification
The hardest case to reach is clearing GO while a memory access is still outstanding. The stop must let that access finish and only then report HALT.

To reach it, the bench's memory model holds its acknowledge back for several cycles. The bench waits until it sees a request pending, then issues the clear-GO write inside that window. From there it checks three things: HALT rises, the live count equals the starting count minus the accesses actually seen, and no further request appears while the peripheral keeps asking.

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan #(
  parameter int AW  = 32,
  parameter int HW  = 4,
  parameter int CW  = 16,
  parameter int DW  = 32,
  parameter int RAW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [HW+AW-1:0]  mem_addr,
  output logic [1:0]        mem_size,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack,
  input  logic              per_req,
  output logic              per_ack,
  output logic [31:0]       per_addr,
  input  logic [DW-1:0]     per_rdata,
  output logic [DW-1:0]     per_wdata,
  output logic              irq
);
  localparam logic [RAW-1:0] OFS_SET = RAW'(5'h00);
  localparam logic [RAW-1:0] OFS_CLR = RAW'(5'h04);
  localparam logic [RAW-1:0] OFS_PER = RAW'(5'h08);
  localparam logic [RAW-1:0] OFS_S0  = RAW'(5'h0C);
  localparam logic [RAW-1:0] OFS_C0  = RAW'(5'h10);
  localparam logic [RAW-1:0] OFS_S1  = RAW'(5'h14);
  localparam logic [RAW-1:0] OFS_C1  = RAW'(5'h18);
  localparam logic [19:0] SET_MASK = 20'hFBFA5;
  localparam logic [19:0] CLR_MASK = 20'hFBFAF;

  typedef enum logic [1:0] {IDLE, XFER, DONE} st_t;

  st_t             st_q;
  logic [19:0]     mode_q, mode_d;
  logic [AW-1:0]   start_q [2];
  logic [CW-1:0]   cnt_q   [2];
  logic [HW-1:0]   hi_q    [2];
  logic [31:0]     per_q;
  logic [DW-1:0]   data_q;
  logic [AW-1:0]   step;

  wire       ab     = mode_q[4];
  wire       go     = mode_q[5];
  wire       dr     = mode_q[12];
  wire [1:0] w      = mode_q[10:9];
  wire       be_act = ab ? mode_q[2] : mode_q[0];
  wire [CW-1:0] cnt_act = cnt_q[ab];
  wire       wr_set = reg_wr && (reg_addr == OFS_SET);
  wire       wr_clr = reg_wr && (reg_addr == OFS_CLR);
  wire       launch = (st_q == IDLE) && go && be_act && (cnt_act != '0) && per_req;
  wire       finish = ((st_q == DONE) && (cnt_act == CW'(1))) ||
                      ((st_q == IDLE) && go && be_act && (cnt_act == '0));

  assign step = (w == 2'd0) ? AW'(1) : (w == 2'd1) ? AW'(2) : AW'(4);

  always_comb begin
    mode_d = mode_q;
    if (wr_set) mode_d = mode_d | (reg_wdata[19:0] & SET_MASK);
    if (wr_clr) mode_d = mode_d & ~(reg_wdata[19:0] & CLR_MASK);
    if (finish) begin
      mode_d[{ab, 1'b0}] = 1'b0;
      mode_d[{ab, 1'b1}] = 1'b1;
      mode_d[4]          = ~ab;
    end
    if (wr_set && reg_wdata[5])        mode_d[6] = 1'b0;
    else if (!go && st_q == IDLE)      mode_d[6] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= IDLE;
      mode_q  <= 20'h00040;
      per_q   <= '0;
      data_q  <= '0;
      for (int i = 0; i < 2; i++) begin
        start_q[i] <= '0;
        cnt_q[i]   <= '0;
        hi_q[i]    <= '0;
      end
    end else begin
      mode_q <= mode_d;
      if (reg_wr) begin
        case (reg_addr)
          OFS_PER: per_q <= reg_wdata;
          OFS_S0:  start_q[0] <= reg_wdata[AW-1:0];
          OFS_S1:  start_q[1] <= reg_wdata[AW-1:0];
          OFS_C0:  begin cnt_q[0] <= reg_wdata[CW-1:0]; hi_q[0] <= reg_wdata[CW+:HW]; end
          OFS_C1:  begin cnt_q[1] <= reg_wdata[CW-1:0]; hi_q[1] <= reg_wdata[CW+:HW]; end
          default: ;
        endcase
      end
      case (st_q)
        IDLE: if (launch) begin
          st_q   <= XFER;
          data_q <= per_rdata;
        end
        XFER: if (mem_ack) begin
          st_q <= DONE;
          if (dr) data_q <= mem_rdata;
        end
        DONE: begin
          st_q        <= IDLE;
          cnt_q[ab]   <= cnt_act - CW'(1);
          start_q[ab] <= start_q[ab] + step;
        end
        default: st_q <= IDLE;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_SET: reg_rdata = {12'b0, mode_q};
      OFS_PER: reg_rdata = per_q;
      OFS_S0:  reg_rdata = 32'(start_q[0]);
      OFS_S1:  reg_rdata = 32'(start_q[1]);
      OFS_C0:  reg_rdata = 32'({hi_q[0], cnt_q[0]});
      OFS_C1:  reg_rdata = 32'({hi_q[1], cnt_q[1]});
      default: reg_rdata = '0;
    endcase
  end

  assign mem_req   = (st_q == XFER);
  assign mem_we    = ~dr;
  assign mem_addr  = {hi_q[ab], start_q[ab]};
  assign mem_size  = w;
  assign mem_wdata = data_q;
  assign per_wdata = data_q;
  assign per_ack   = (st_q == DONE);
  assign per_addr  = per_q;
  assign irq       = mode_q[7] & (mode_q[1] | mode_q[3]);
endmodule

// File: rtl/dbuf_dma_chk.sv
module dbuf_dma_chk #(
  parameter int MAW = 36
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic           mem_ack,
  input logic [MAW-1:0] mem_addr,
  input logic           per_ack,
  input logic           irq,
  input logic [19:0]    mode
);
  a_r3_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> per_ack);
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  a_r8_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mode[6] |-> !mem_req);
  a_r9_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[7] |-> !irq);
  a_r5_done_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode[1]) |-> !mode[0]);
  a_r7_start_under_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(mode[5]));
endmodule

bind dbuf_dma_chan dbuf_dma_chk #(.MAW(HW+AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .per_ack(per_ack), .irq(irq), .mode(mode_q)
);

// File: tb/sim_dbuf_dma_chan.sv
`timescale 1ns/1ps
module sim_dbuf_dma_chan;
  localparam int MAW = 36;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [4:0] reg_addr = 0; logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 0; logic [MAW-1:0] mem_addr; logic [1:0] mem_size;
  logic [31:0] mem_wdata, mem_rdata = 0;
  logic per_req = 0, per_ack; logic [31:0] per_addr, per_rdata = 0, per_wdata;
  logic irq;

  int n_chk = 0, n_err = 0, n_acc = 0, ack_delay = 0;
  logic [MAW+32:0] q[$];

  dbuf_dma_chan u0 (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_mode(int b, logic v);
    logic [31:0] m;
    for (int i = 0; i < 400; i++) begin
      rd(5'h00, m);
      if (m[b] == v) return;
    end
  endtask

  task automatic push(logic [MAW-1:0] a, logic we, logic [31:0] d);
    q.push_back({a, we, d});
  endtask

  // memory model and scoreboard monitor
  initial begin
    int wc = 0;
    logic rd_pend = 0;
    logic [31:0] last_rd = 0;
    logic [MAW+32:0] e;
    forever begin
      @(negedge clk);
      if (per_ack && rd_pend) begin
        chk("R3 per_wdata from memory read", per_wdata, last_rd);
        rd_pend = 0;
      end
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        if (wc < ack_delay) wc++;
        else begin
          wc = 0;
          n_acc++;
          if (q.size() == 0) chk("R3 unexpected access", mem_addr, '1);
          else begin
            e = q.pop_front();
            chk("R3 access address", mem_addr, e[MAW+32:33]);
            chk("R3 access direction", mem_we, e[32]);
            if (e[32]) chk("R3 write data", mem_wdata, e[31:0]);
          end
          mem_rdata = mem_addr[31:0] ^ 32'h5A5A0000;
          if (!mem_we) begin rd_pend = 1; last_rd = mem_rdata; end
          mem_ack = 1;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] m;
    int n0, n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(5'h00, m); chk("R1 reset mode", m, 32'h40);
    chk("R9 reset irq", irq, 0);
    chk("R3 reset no request", mem_req, 0);

    wr(5'h08, 32'h1234_5678);
    rd(5'h08, m); chk("R10 periph readback", m, 32'h1234_5678);
    chk("R10 per_addr", per_addr, 32'h1234_5678);

    wr(5'h00, 32'hFFFF_FFDF);
    rd(5'h00, m); chk("R1 R2 set mask", m, 32'hFBFC5);
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h00, m); chk("R1 clear all", m, 32'h40);
    wr(5'h00, 32'h000A_0000);
    rd(5'h00, m); chk("R10 device id", m, 32'hA0040);
    wr(5'h04, 32'h000F_0000);

    // R3 R4 R5: peripheral to memory, 32-bit, both buffers
    per_rdata = 32'hCAFE_0001;
    wr(5'h0C, 32'h1000); wr(5'h10, 32'h0003_0003);
    wr(5'h14, 32'h2000); wr(5'h18, 32'h0005_0002);
    for (int i = 0; i < 3; i++) push(36'h3_0000_1000 + 36'(4*i), 1, 32'hCAFE_0001);
    for (int i = 0; i < 2; i++) push(36'h5_0000_2000 + 36'(4*i), 1, 32'hCAFE_0001);
    wr(5'h00, 32'h485);
    wr(5'h00, 32'h20);
    per_req = 1;
    wait_mode(3, 1);
    per_req = 0;
    rd(5'h00, m); chk("R5 both buffers done, AB back to 0", m, 32'h4AA);
    chk("R9 irq with done", irq, 1);
    rd(5'h10, m); chk("R4 live count0", m, 32'h0003_0000);
    rd(5'h0C, m); chk("R4 live start0 32-bit step", m, 32'h100C);
    rd(5'h14, m); chk("R6 live start1", m, 32'h2008);
    chk("R3 all accesses seen", q.size(), 0);
    wr(5'h04, 32'h20); wait_mode(6, 1);

    wr(5'h04, 32'h2);
    #1 chk("R9 irq with D1 only", irq, 1);
    wr(5'h04, 32'h8);
    #1 chk("R9 irq cleared", irq, 0);
    rd(5'h00, m); chk("R2 done flags cleared", m[3:0], 0);

    // R7: active buffer 0 not enabled, buffer 1 enabled
    n0 = n_acc;
    wr(5'h00, 32'h24);
    per_req = 1;
    repeat (20) @(negedge clk);
    per_req = 0;
    chk("R7 no access on disabled buffer", n_acc, n0);
    rd(5'h00, m); chk("R7 AB unchanged, BE1 kept", {m[4], m[2]}, 2'b01);
    wr(5'h04, 32'h24); wait_mode(6, 1);

    // R3 R6: memory to peripheral, 16-bit
    wr(5'h04, 32'h600); wr(5'h00, 32'h1200);
    wr(5'h0C, 32'h40); wr(5'h10, 32'h2);
    push(36'h40, 0, 0); push(36'h42, 0, 0);
    wr(5'h00, 32'h21);
    per_req = 1;
    wait_mode(1, 1);
    per_req = 0;
    rd(5'h00, m); chk("R6 AB reads 1 after buffer 0", m[4], 1);
    rd(5'h0C, m); chk("R4 start0 16-bit step", m, 32'h44);
    rd(5'h10, m); chk("R4 count0 zero", m, 0);
    wr(5'h14, 32'h80); wr(5'h18, 32'h0002_0001);
    push(36'h2_0000_0080, 0, 0);
    per_req = 1;
    wr(5'h00, 32'h4);
    wait_mode(3, 1);
    per_req = 0;
    rd(5'h00, m); chk("R6 AB back to 0 after buffer 1", m[4], 0);
    chk("R6 buffer 1 access used", q.size(), 0);
    wr(5'h04, 32'h2A); wait_mode(6, 1);

    // R5: zero count completes without access
    n0 = n_acc;
    wr(5'h04, 32'h1000);
    wr(5'h10, 32'h0);
    wr(5'h00, 32'h21);
    wait_mode(1, 1);
    rd(5'h00, m); chk("R5 zero count: D0 set, BE0 clear, AB=1", {m[4], m[1], m[0]}, 3'b110);
    chk("R5 zero count no access", n_acc, n0);
    wr(5'h04, 32'h2A); wait_mode(6, 1);

    // R8: halt with access in flight, 8-bit on buffer 1
    wr(5'h04, 32'h600);
    per_rdata = 32'h11;
    ack_delay = 4;
    wr(5'h14, 32'h0); wr(5'h18, 32'd100);
    for (int i = 0; i < 10; i++) push(36'(i), 1, 32'h11);
    n0 = n_acc;
    wr(5'h00, 32'h24);
    per_req = 1;
    for (int i = 0; i < 50 && !mem_req; i++) @(negedge clk);
    wr(5'h04, 32'h20);
    wait_mode(6, 1);
    rd(5'h00, m); chk("R8 HALT after GO cleared", m[6], 1);
    n = n_acc - n0;
    chk("R8 in-flight transfer completed", n > 0, 1);
    rd(5'h18, m); chk("R4 R8 live count after stop", m, 32'(100 - n));
    rd(5'h14, m); chk("R4 8-bit step", m, 32'(n));
    n0 = n_acc;
    repeat (30) @(negedge clk);
    chk("R8 no access while halted", n_acc, n0);
    per_req = 0;
    q.delete();
    wr(5'h00, 32'h20);
    rd(5'h00, m); chk("R8 HALT cleared by GO", m[6], 0);
    wr(5'h04, 32'h24);
    wait_mode(6, 1);
    repeat (5) @(negedge clk);
    report();
  end
endmodule